// File: doc/BRIEF.md
# Reference Divider, Phase-Frequency Detector and Lock Flag

This block sits in the digital section of a frequency synthesizer loop. It divides a reference waveform by a programmable ratio R+1 to make the comparison clock, and it compares that clock with a feedback pulse train that comes from the loop's main divider. Both inputs are level signals, sampled by a fast sampling clock, and their rising edges drive a tri-state phase-frequency detector. The detector raises an up request when the comparison clock arrives first and a down request when the feedback arrives first. The request stays high for as long as the other edge has not yet come.

The OR of the two requests is also brought out, so that a pin can feed an external integrating capacitor. Inside the block a digital filter takes the place of that capacitor. It measures how many sampling cycles of detector activity fall in each comparison period. It declares lock once enough consecutive periods stay within a tolerance, and it drops lock at the first period that goes past that tolerance. A power-down input holds the divider, the detector and the filter cleared.

Top module: `refdiv_pfd_lock`

## Requirements
- R1: `fc_out` is high for exactly one sampling cycle once every R+1 rising edges of `ref_in`, where R is `r_div` (6 bits, 0 to 63). Counting starts at reset, so the first pulse follows the (R+1)-th rise, and R = 0 gives one pulse per reference rise. The pulse appears in the cycle after the sampling edge that first sees the rising reference.
- R2: An input edge is a rising edge when the input is sampled low at one clock edge and high at the next. Levels that do not change start no event.
- R3: When the comparison pulse comes D cycles before the feedback edge is sampled, `up_out` is high for D+1 consecutive cycles, starting one cycle after the `fc_out` pulse. `dn_out` is high for one cycle, in the last of those cycles.
- R4: When the feedback edge comes before the comparison pulse, `dn_out` rises in the cycle after the feedback edge is sampled and stays high until the comparison pulse sets `up_out`. `up_out` is then high for one cycle.
- R5: A cycle in which `up_out` and `dn_out` are both high is followed by a cycle in which both are low. When the two edges are sampled at the same clock edge, both outputs are high for exactly one cycle.
- R6: `or_out` equals `up_out` OR `dn_out` in every cycle.
- R7: A comparison period is quiet if `or_out` is high for no more than `lock_tol` cycles within it. `lock_out` rises one cycle after the `fc_out` pulse that closes the `lock_periods`-th consecutive quiet period.
- R8: `lock_out` falls one cycle after the `fc_out` pulse that closes the first period in which `or_out` was high for more than `lock_tol` cycles. The quiet-period count then starts again from zero.
- R9: While `pwr_dn` is high, starting with the cycle after it is first sampled, `fc_out`, `up_out`, `dn_out` and `lock_out` are low. After `pwr_dn` is released, both the divider count and the quiet-period count start again from zero.
- R10: After a synchronous reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_dn | input | 1 | Holds divider, detector and filter cleared |
| ref_in | input | 1 | Reference waveform, sampled |
| fb_in | input | 1 | Divided feedback pulse, sampled |
| r_div | input | 6 | Reference ratio minus one |
| lock_periods | input | 8 | Consecutive quiet periods needed for lock |
| lock_tol | input | 8 | Highest count of active cycles a quiet period may hold |
| fc_out | output | 1 | Comparison pulse, one cycle wide |
| up_out | output | 1 | Raise-frequency request |
| dn_out | output | 1 | Lower-frequency request |
| or_out | output | 1 | OR of up and down for external integration |
| lock_out | output | 1 | Lock indication |

## Verification
A wrong divider count shows up within one comparison period, as a missing or extra `fc_out` pulse over a known count of reference rises. A detector flip-flop stuck set or cleared changes the measured `up_out` and `dn_out` widths in the very period where it happens, and a missed mutual clear breaks the one-cycle overlap at once. A wrong quiet count or a missed window reset in the filter moves the `lock_out` edge by whole comparison periods, so the bench compares that edge against the exact `fc_out` pulse where it must fall.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Pair of detector request flags.
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_flags_t;

  // Verdict given to one comparison window by the lock filter.
  typedef enum logic {
    WIN_QUIET = 1'b0,
    WIN_NOISY = 1'b1
  } win_verdict_t;

endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int R_W = 6
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           ref_in,
  input  logic [R_W-1:0] r_div,
  output logic           fc_pulse
);

  logic           ref_q;
  logic [R_W-1:0] edge_cnt;
  logic           ref_rise;

  assign ref_rise = ref_in & ~ref_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      ref_q    <= 1'b0;
      edge_cnt <= '0;
      fc_pulse <= 1'b0;
    end else begin
      ref_q    <= ref_in;
      fc_pulse <= 1'b0;
      if (ref_rise) begin
        // >= keeps the counter bounded if the ratio shrinks mid-count
        if (edge_cnt >= r_div) begin
          edge_cnt <= '0;
          fc_pulse <= 1'b1;
        end else begin
          edge_cnt <= edge_cnt + 1'b1;
        end
      end
    end
  end

  // A reference rise needs a low sample first, so pulses never touch.
  assert_fc_single_R1: assert property (@(posedge clk) disable iff (clr)
    fc_pulse |=> !fc_pulse);

endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic fc_evt,
  input  logic fb_in,
  output logic up,
  output logic dn
);

  logic       fb_q;
  logic       fb_rise;
  pfd_flags_t st;

  assign fb_rise = fb_in & ~fb_q;
  assign up = st.up;
  assign dn = st.dn;

  always_ff @(posedge clk) begin
    if (clr) begin
      fb_q <= 1'b0;
      st   <= '0;
    end else begin
      fb_q <= fb_in;
      if (st.up && st.dn) begin
        // mutual clear: overlap lasts exactly one sampling cycle
        st <= '0;
      end else begin
        st.up <= st.up | fc_evt;
        st.dn <= st.dn | fb_rise;
      end
    end
  end

  assert_overlap_clears_R5: assert property (@(posedge clk) disable iff (clr)
    (up && dn) |=> (!up && !dn));

  assert_up_from_fc_R3: assert property (@(posedge clk) disable iff (clr)
    $rose(up) |-> $past(fc_evt));

  assert_dn_from_fb_R4: assert property (@(posedge clk) disable iff (clr)
    $rose(dn) |-> $past(fb_rise));

endmodule

// File: rtl/lock_filter.sv
module lock_filter
  import pfd_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int TOL_W = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             fc_evt,
  input  logic             or_in,
  input  logic [PER_W-1:0] lock_periods,
  input  logic [TOL_W-1:0] lock_tol,
  output logic             lock
);

  localparam int ACT_W = TOL_W + 1;
  localparam logic [ACT_W-1:0] ACT_MAX = '1;
  localparam logic [PER_W-1:0] PER_MAX = '1;

  logic [ACT_W-1:0] act_cnt;
  logic [ACT_W:0]   act_total;
  logic [PER_W-1:0] quiet_cnt;
  logic [PER_W-1:0] quiet_nx;
  win_verdict_t     verdict;

  // active cycles of the window closing now, including this cycle
  assign act_total = {1'b0, act_cnt} + {{ACT_W{1'b0}}, or_in};
  assign verdict   = (act_total > {2'b00, lock_tol}) ? WIN_NOISY : WIN_QUIET;
  assign quiet_nx  = (quiet_cnt == PER_MAX) ? quiet_cnt : quiet_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (clr) begin
      act_cnt   <= '0;
      quiet_cnt <= '0;
      lock      <= 1'b0;
    end else if (fc_evt) begin
      act_cnt <= '0;
      if (verdict == WIN_NOISY) begin
        quiet_cnt <= '0;
        lock      <= 1'b0;
      end else begin
        quiet_cnt <= quiet_nx;
        // a zero setting behaves as one since quiet_nx is at least one
        lock      <= (quiet_nx >= lock_periods);
      end
    end else if (or_in && act_cnt != ACT_MAX) begin
      act_cnt <= act_cnt + 1'b1;
    end
  end

  assert_lock_rise_on_fc_R7: assert property (@(posedge clk) disable iff (clr)
    $rose(lock) |-> $past(fc_evt));

  assert_lock_fall_on_fc_R8: assert property (@(posedge clk) disable iff (clr)
    $fell(lock) |-> ($past(fc_evt) || $past(clr)));

endmodule

// File: rtl/refdiv_pfd_lock.sv
module refdiv_pfd_lock #(
  parameter int R_W   = 6,
  parameter int PER_W = 8,
  parameter int TOL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_dn,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [R_W-1:0]   r_div,
  input  logic [PER_W-1:0] lock_periods,
  input  logic [TOL_W-1:0] lock_tol,
  output logic             fc_out,
  output logic             up_out,
  output logic             dn_out,
  output logic             or_out,
  output logic             lock_out
);

  logic clr;
  logic fc_pulse;
  logic up_r;
  logic dn_r;
  logic lock_r;

  assign clr = rst | pwr_dn;

  ref_divider #(.R_W(R_W)) u_div (
    .clk      (clk),
    .clr      (clr),
    .ref_in   (ref_in),
    .r_div    (r_div),
    .fc_pulse (fc_pulse)
  );

  pfd_core u_pfd (
    .clk    (clk),
    .clr    (clr),
    .fc_evt (fc_pulse),
    .fb_in  (fb_in),
    .up     (up_r),
    .dn     (dn_r)
  );

  lock_filter #(.PER_W(PER_W), .TOL_W(TOL_W)) u_lock (
    .clk          (clk),
    .clr          (clr),
    .fc_evt       (fc_pulse),
    .or_in        (or_out),
    .lock_periods (lock_periods),
    .lock_tol     (lock_tol),
    .lock         (lock_r)
  );

  // all sources are flip-flops, so the OR stays free of input glitches
  assign fc_out   = fc_pulse;
  assign up_out   = up_r;
  assign dn_out   = dn_r;
  assign or_out   = up_r | dn_r;
  assign lock_out = lock_r;

  assert_pd_silent_R9: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> (!fc_out && !up_out && !dn_out && !lock_out));

endmodule

// File: tb/refdiv_pfd_lock_test.sv
module refdiv_pfd_lock_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_dn = 1'b0;
  logic       ref_in = 1'b0;
  logic       fb_man = 1'b0;
  logic       fb_follow = 1'b0;
  logic       fb_in;
  logic [5:0] r_div = '0;
  logic [7:0] lock_periods = 8'd4;
  logic [7:0] lock_tol = 8'd1;
  logic       fc_out, up_out, dn_out, or_out, lock_out;

  int n_checks = 0;
  int n_fail = 0;

  // stimulus state
  bit ref_run = 0;
  int ref_half = 2;
  int ref_ph = 0;
  int ref_rises = 0;
  int fc_seen = 0;
  bit follow_en = 0;
  int follow_d = 0;
  bit armed = 0;
  int wctr = 0;

  always #5 clk = ~clk;

  assign fb_in = follow_en ? fb_follow : fb_man;

  refdiv_pfd_lock uut (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .ref_in(ref_in), .fb_in(fb_in),
    .r_div(r_div), .lock_periods(lock_periods), .lock_tol(lock_tol),
    .fc_out(fc_out), .up_out(up_out), .dn_out(dn_out), .or_out(or_out),
    .lock_out(lock_out)
  );

  // reference waveform generator
  always @(negedge clk) begin
    if (!ref_run) begin
      ref_in = 1'b0;
      ref_ph = 0;
    end else begin
      ref_ph++;
      if (ref_ph >= ref_half) begin
        ref_ph = 0;
        ref_in = ~ref_in;
        if (ref_in) ref_rises++;
      end
    end
  end

  // counts comparison pulses; optional feedback that follows fc by follow_d
  always @(negedge clk) begin
    if (fc_out) fc_seen++;
    if (follow_en) begin
      if (fb_follow) fb_follow = 1'b0;
      if (fc_out) begin
        armed = 1;
        wctr = follow_d;
      end
      if (armed) begin
        if (wctr == 0) begin
          fb_follow = 1'b1;
          armed = 0;
        end else begin
          wctr--;
        end
      end
    end else begin
      fb_follow = 1'b0;
      armed = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    ref_run = 0;
    follow_en = 0;
    fb_man = 1'b0;
    pwr_dn = 1'b0;
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    fc_seen = 0;
    ref_rises = 0;
  endtask

  task automatic wait_fc();
    do tick(); while (!fc_out);
  endtask

  task automatic wait_fc_count(input int k);
    while (fc_seen < k) tick();
  endtask

  // R10: all outputs low after reset
  task automatic test_reset();
    do_reset();
    chk({fc_out, up_out, dn_out, or_out, lock_out} == 5'b0, "R10 outputs after reset",
        {fc_out, up_out, dn_out, or_out, lock_out}, 0);
  endtask

  // R1/R2: pulse count and width over a known number of reference rises
  task automatic test_divider(input int r, input int half, input int nrise);
    int cnt = 0;
    bit prev = 0;
    int wide = 0;
    r_div = r[5:0];
    do_reset();
    ref_half = half;
    ref_run = 1;
    while (ref_rises < nrise) begin
      tick();
      if (fc_out) cnt++;
      if (fc_out && prev) wide++;
      prev = fc_out;
    end
    ref_run = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      if (fc_out) cnt++;
      if (fc_out && prev) wide++;
      prev = fc_out;
    end
    chk(cnt == nrise / (r + 1), "R1 fc pulse count", cnt, nrise / (r + 1));
    chk(wide == 0, "R1_R2 fc one cycle wide", wide, 0);
  endtask

  // R3/R5/R6: comparison pulse leads feedback by d cycles
  task automatic measure_fc_lead(input int d);
    int cu = 0;
    int cd = 0;
    int both = 0;
    int orbad = 0;
    wait_fc();
    if (d == 0) fb_man = 1'b1;
    for (int i = 1; i <= 7; i++) begin
      tick();
      if (up_out) cu++;
      if (dn_out) cd++;
      if (up_out && dn_out) both++;
      if (or_out != (up_out | dn_out)) orbad++;
      if (i == d) fb_man = 1'b1;
      if (i == d + 1) fb_man = 1'b0;
    end
    chk(cu == d + 1, "R3 up width", cu, d + 1);
    chk(cd == 1, "R3 dn width when fc leads", cd, 1);
    chk(both == 1, "R5 single overlap cycle", both, 1);
    chk(orbad == 0, "R6 or equals up|dn", orbad, 0);
  endtask

  task automatic test_fc_leads();
    r_div = 6'd1;
    do_reset();
    ref_half = 2;
    ref_run = 1;
    // same-edge case: both high one cycle, then both low
    wait_fc();
    fb_man = 1'b1;
    tick();
    fb_man = 1'b0;
    chk(up_out && dn_out, "R5 same-edge overlap", {up_out, dn_out}, 3);
    tick();
    chk(!up_out && !dn_out, "R5 cleared after overlap", {up_out, dn_out}, 0);
    measure_fc_lead(0);
    measure_fc_lead(3);
    measure_fc_lead(5);
    ref_run = 0;
  endtask

  // R4: feedback leads comparison pulse; fc period is 8 cycles here
  task automatic measure_fb_lead(input int lead);
    int cu = 0;
    int cd = 0;
    wait_fc();
    fb_man = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      tick();
      if (i >= 3) begin
        if (up_out) cu++;
        if (dn_out) cd++;
      end
      if (i == 1) fb_man = 1'b0;
      if (i == lead) fb_man = 1'b1;
      if (i == lead + 1) fb_man = 1'b0;
    end
    chk(cd == 8 - lead + 1, "R4 dn width", cd, 8 - lead + 1);
    chk(cu == 1, "R4 up width when fb leads", cu, 1);
  endtask

  task automatic test_fb_leads();
    r_div = 6'd1;
    do_reset();
    ref_half = 2;
    ref_run = 1;
    measure_fb_lead(4);
    measure_fb_lead(6);
    ref_run = 0;
  endtask

  // R7/R8: lock after 4 quiet periods, drop on first noisy one
  task automatic test_lock();
    r_div = 6'd1;
    lock_periods = 8'd4;
    lock_tol = 8'd1;
    do_reset();
    follow_d = 0;
    follow_en = 1;
    ref_half = 2;
    ref_run = 1;
    wait_fc_count(3);
    tick();
    chk(!lock_out, "R7 no lock after 3 quiet periods", lock_out, 0);
    wait_fc_count(4);
    tick();
    chk(lock_out, "R7 lock after 4 quiet periods", lock_out, 1);
    wait_fc_count(6);
    tick();
    tick();
    follow_d = 3;
    wait_fc_count(7);
    tick();
    chk(lock_out, "R8 lock held until noisy window closes", lock_out, 1);
    wait_fc_count(8);
    tick();
    chk(!lock_out, "R8 lock drops after noisy window", lock_out, 0);
    follow_d = 0;
    wait_fc_count(9);
    tick();
    chk(!lock_out, "R8 quiet count restarted", lock_out, 0);
    ref_run = 0;
    follow_en = 0;
  endtask

  // R9: power-down silences outputs, counts restart afterwards
  task automatic test_powerdown();
    int bad = 0;
    int base;
    r_div = 6'd1;
    lock_periods = 8'd4;
    lock_tol = 8'd1;
    do_reset();
    follow_d = 0;
    follow_en = 1;
    ref_half = 2;
    ref_run = 1;
    wait_fc_count(5);
    tick();
    chk(lock_out, "R9 locked before power-down", lock_out, 1);
    pwr_dn = 1'b1;
    for (int i = 0; i < 24; i++) begin
      tick();
      if (fc_out || up_out || dn_out || lock_out) bad++;
    end
    chk(bad == 0, "R9 outputs low in power-down", bad, 0);
    pwr_dn = 1'b0;
    base = fc_seen;
    wait_fc_count(base + 1);
    tick();
    chk(!lock_out, "R9 lock restarts after power-down", lock_out, 0);
    wait_fc_count(base + 4);
    tick();
    chk(lock_out, "R9 relock after 4 periods", lock_out, 1);
    ref_run = 0;
    follow_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    test_reset();
    test_divider(3, 2, 40);
    test_divider(0, 1, 12);
    test_divider(5, 1, 18);
    test_divider(63, 1, 128);
    test_fc_leads();
    test_fb_leads();
    test_lock();
    test_powerdown();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule